// File: doc/BRIEF.md
# Channel Transmit Stop Controller

This block carries out a stop-transmit request for one channel of a byte-oriented HDLC-style multichannel transmitter. It sits between the host command path and the channel's serializer. While the channel is running it passes the serializer's byte requests through as data. When a stop strobe arrives it drops the transmit enable, sends a one-cycle pulse that clears the channel's poll bit, and freezes a copy of the buffer pointer that was in use at that moment. The serializer is then told which symbol to send on each later byte request.

The action depends on where the stop falls in the frame. If a frame is in progress, the channel sends an abort indication first. This is one or more all-ones bytes, which is enough to break any frame. After that the channel falls back to fill. If the stop falls between frames, the channel goes straight to fill. The fill is the flag byte or the all-ones idle byte, as chosen by the channel's idle-mode input. After a stop the host must first signal that it has reinitialized the channel. Only then does a restart strobe bring data transmission back.

The controller has four states. RUN means data is being transmitted. ABORT means abort bytes are being sent. HALT means the channel is stopped and waiting for reinitialization. ARMED means the channel has been reinitialized and is waiting for restart. The transitions are:
- RUN goes to ABORT on a stop with a frame in progress, and to HALT on a stop between frames.
- ABORT goes to HALT on the byte request that takes the last abort byte.
- HALT goes to ARMED on reinit.
- ARMED goes to RUN on restart, and back to HALT on a stop.

Reset enters HALT.

Top module: `tx_stop_ctrl`

## Requirements
- R1: After reset the state is HALT. In that state `tx_en` is 0, `poll_clr` is 0 and `saved_ptr` is 0, and `sym_sel`/`sym_byte` show fill according to `idle_mode`.
- R2: A `stop_req` that is sampled while `tx_en` is 1 makes `tx_en` 0 from the next cycle on.
- R3: A stop that is accepted while running raises `poll_clr` for exactly one cycle. This is the cycle right after the stop is sampled.
- R4: A stop with `in_frame`=1 selects abort (`sym_sel`=1, `sym_byte`=0xFF). The abort selection holds for ABORT_LEN byte requests (default 1), and fill follows after that.
- R5: A stop with `in_frame`=0 selects fill from the next cycle. No abort byte is sent.
- R6: Fill follows `idle_mode` live. With `idle_mode`=1 the flag is selected (`sym_sel`=3, `sym_byte`=0x7E). With `idle_mode`=0 idle is selected (`sym_sel`=2, `sym_byte`=0xFF). The same symbol repeats on every byte request while stopped.
- R7: While running, `saved_ptr` takes the value of `buf_ptr_in` one cycle later. After a stop it holds the pointer that was present with the stop strobe, whatever `buf_ptr_in` does afterwards.
- R8: `restart` has no effect in HALT. After `reinit` (HALT to ARMED), a `restart` gives `tx_en`=1 and data selection (`sym_sel`=0, `sym_byte`=0x00) from the next cycle.
- R9: A `stop_req` that arrives while not running does not pulse `poll_clr` and does not change `saved_ptr`. In ARMED it cancels the arming and returns to HALT, so that a following `restart` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stop_req | input | 1 | Stop-transmit strobe |
| in_frame | input | 1 | A frame is currently being sent |
| idle_mode | input | 1 | Fill selection: 1 selects flags, 0 selects idle ones |
| buf_ptr_in | input | PTR_W | Current transmit buffer pointer |
| byte_req | input | 1 | Serializer takes a byte this cycle |
| reinit | input | 1 | Host has reinitialized the channel |
| restart | input | 1 | Request to resume data transmission |
| tx_en | output | 1 | Channel transmit enable |
| poll_clr | output | 1 | One-cycle pulse that clears the poll bit |
| sym_sel | output | 2 | 0 data, 1 abort, 2 idle, 3 flag |
| sym_byte | output | 8 | Byte for non-data symbols (0x00 for data) |
| saved_ptr | output | PTR_W | Buffer pointer held for the host |

## Verification
All state changes happen on the clock edge at which an input strobe is sampled. `tx_en`, `sym_sel` and `sym_byte` are decoded from the state, so they show the new value in the same cycle, one edge after the strobe. `poll_clr` and `saved_ptr` are registered and also change on that edge. `poll_clr` drops again one edge later. The bench drives every input on the falling edge and samples outputs on the next falling edge. Expected symbols are queued when a byte request is driven, and they are compared while that request is still high, so each request is checked against the symbol it takes.

// File: rtl/tx_stop_pkg.sv
package tx_stop_pkg;
    typedef enum logic [1:0] {
        SYM_DATA  = 2'd0,
        SYM_ABORT = 2'd1,
        SYM_IDLE  = 2'd2,
        SYM_FLAG  = 2'd3
    } sym_sel_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ABORT = 2'd1,
        ST_HALT  = 2'd2,
        ST_ARMED = 2'd3
    } stop_state_e;
endpackage

// File: rtl/tx_stop_fsm.sv
module tx_stop_fsm
    import tx_stop_pkg::*;
#(
    parameter int ABORT_LEN = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     stop_req,
    input  logic     in_frame,
    input  logic     idle_mode,
    input  logic     byte_req,
    input  logic     reinit,
    input  logic     restart,
    output logic     tx_en,
    output logic     poll_clr,
    output sym_sel_e sel
);
    localparam int CNT_W = (ABORT_LEN > 1) ? $clog2(ABORT_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ABORT_LEN - 1);

    stop_state_e state, state_nx;
    logic [CNT_W-1:0] abort_cnt;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (stop_req) state_nx = in_frame ? ST_ABORT : ST_HALT;
            ST_ABORT: if (byte_req && abort_cnt == LAST) state_nx = ST_HALT;
            ST_HALT:  if (reinit) state_nx = ST_ARMED;
            ST_ARMED: begin
                if (stop_req)     state_nx = ST_HALT;
                else if (restart) state_nx = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HALT;
            abort_cnt <= '0;
            poll_clr  <= 1'b0;
        end else begin
            state    <= state_nx;
            poll_clr <= (state == ST_RUN) && stop_req;
            if (state != ST_ABORT)
                abort_cnt <= '0;
            else if (byte_req)
                abort_cnt <= abort_cnt + 1'b1;
        end
    end

    always_comb begin
        tx_en = 1'b0;
        sel   = idle_mode ? SYM_FLAG : SYM_IDLE;
        unique case (state)
            ST_RUN:   begin tx_en = 1'b1; sel = SYM_DATA; end
            ST_ABORT: sel = SYM_ABORT;
            ST_HALT:  ;
            ST_ARMED: ;
        endcase
    end

    // R8: restart without prior reinit keeps the channel stopped
    a_r8_restart_needs_reinit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> !tx_en);
    // R4: abort lasts while fewer than ABORT_LEN bytes have been taken
    a_r4_abort_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT) |-> (abort_cnt <= LAST));
    // R9: stop while armed cancels arming
    a_r9_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && stop_req) |=> (state == ST_HALT && !poll_clr));
endmodule

// File: rtl/tx_stop_sym.sv
module tx_stop_sym
    import tx_stop_pkg::*;
#(
    parameter logic [7:0] FLAG_BYTE  = 8'h7E,
    parameter logic [7:0] IDLE_BYTE  = 8'hFF,
    parameter logic [7:0] ABORT_BYTE = 8'hFF
) (
    input  sym_sel_e   sel,
    output logic [7:0] sym_byte
);
    always_comb begin
        unique case (sel)
            SYM_DATA:  sym_byte = 8'h00;
            SYM_ABORT: sym_byte = ABORT_BYTE;
            SYM_IDLE:  sym_byte = IDLE_BYTE;
            SYM_FLAG:  sym_byte = FLAG_BYTE;
        endcase
    end
endmodule

// File: rtl/tx_stop_ptr.sv
module tx_stop_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             track,
    input  logic [PTR_W-1:0] ptr_in,
    output logic [PTR_W-1:0] ptr_hold
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_hold <= '0;
        else if (track)
            ptr_hold <= ptr_in;
    end

    // R7: the held pointer is frozen while not tracking
    a_r7_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !track |=> $stable(ptr_hold));
endmodule

// File: rtl/tx_stop_ctrl.sv
module tx_stop_ctrl
    import tx_stop_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int ABORT_LEN = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_req,
    input  logic             in_frame,
    input  logic             idle_mode,
    input  logic [PTR_W-1:0] buf_ptr_in,
    input  logic             byte_req,
    input  logic             reinit,
    input  logic             restart,
    output logic             tx_en,
    output logic             poll_clr,
    output logic [1:0]       sym_sel,
    output logic [7:0]       sym_byte,
    output logic [PTR_W-1:0] saved_ptr
);
    sym_sel_e sel;

    tx_stop_fsm #(.ABORT_LEN(ABORT_LEN)) fsm_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .in_frame(in_frame),
        .idle_mode(idle_mode), .byte_req(byte_req), .reinit(reinit),
        .restart(restart), .tx_en(tx_en), .poll_clr(poll_clr), .sel(sel)
    );

    tx_stop_sym sym_i (.sel(sel), .sym_byte(sym_byte));

    tx_stop_ptr #(.PTR_W(PTR_W)) ptr_i (
        .clk(clk), .rst_n(rst_n), .track(tx_en),
        .ptr_in(buf_ptr_in), .ptr_hold(saved_ptr)
    );

    assign sym_sel = sel;

    // R2/R3: an accepted stop drops enable and pulses poll clear
    a_r2_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && stop_req) |=> (!tx_en && poll_clr));
    a_r3_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
        poll_clr |=> !poll_clr);
    // R4: stop mid-frame selects abort
    a_r4_abort_first: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && stop_req && in_frame) |=> (sym_sel == 2'd1));
    // R5: stop between frames goes straight to fill
    a_r5_fill_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && stop_req && !in_frame) |=> (sym_sel[1] == 1'b1));
    // R6: enable and data selection go together
    a_r6_data_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> (sym_sel == 2'd0));
endmodule

// File: tb/tx_stop_ctrl_tb_top.sv
module tx_stop_ctrl_tb_top;
    localparam int PTR_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 0, in_frame = 0, idle_mode = 0, byte_req = 0;
    logic reinit = 0, restart = 0;
    logic [PTR_W-1:0] buf_ptr_in = '0;
    logic tx_en, poll_clr;
    logic [1:0] sym_sel;
    logic [7:0] sym_byte;
    logic [PTR_W-1:0] saved_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [9:0] exp_q[$];

    always #4 clk = ~clk;

    tx_stop_ctrl #(.PTR_W(PTR_W), .ABORT_LEN(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .in_frame(in_frame),
        .idle_mode(idle_mode), .buf_ptr_in(buf_ptr_in), .byte_req(byte_req),
        .reinit(reinit), .restart(restart), .tx_en(tx_en), .poll_clr(poll_clr),
        .sym_sel(sym_sel), .sym_byte(sym_byte), .saved_ptr(saved_ptr)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick();
        sig = 1'b0;
    endtask

    task automatic pull(input logic [1:0] sel, input logic [7:0] b);
        exp_q.push_back({sel, b});
        byte_req = 1'b1;
        tick();
        byte_req = 1'b0;
    endtask

    // monitor: compare each byte request with the queued expectation
    always @(negedge clk) begin
        #2;
        if (byte_req) begin
            if (exp_q.size() == 0) begin
                check(0, "SCOREBOARD empty queue", 0, 0);
            end else begin
                logic [9:0] e;
                e = exp_q.pop_front();
                check({sym_sel, sym_byte} == e, "R6 symbol scoreboard",
                      {sym_sel, sym_byte}, e);
            end
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(tx_en == 0, "R1 tx_en", tx_en, 0);
        check(poll_clr == 0, "R1 poll_clr", poll_clr, 0);
        check(saved_ptr == 0, "R1 saved_ptr", saved_ptr, 0);
        check(sym_sel == 2, "R1 sym_sel idle", sym_sel, 2);
        @(negedge clk);

        // R8 restart ignored in HALT
        pulse(restart);
        check(tx_en == 0, "R8 restart ignored", tx_en, 0);
        pull(2'd2, 8'hFF);

        // R8 reinit then restart
        pulse(reinit);
        check(tx_en == 0, "R8 armed not running", tx_en, 0);
        pulse(restart);
        check(tx_en == 1, "R8 running", tx_en, 1);
        pull(2'd0, 8'h00);

        // R7 tracking
        buf_ptr_in = 16'h1234;
        tick();
        check(saved_ptr == 16'h1234, "R7 tracking", saved_ptr, 16'h1234);

        // R2 R3 R4 stop mid-frame
        in_frame = 1'b1;
        pulse(stop_req);
        in_frame = 1'b0;
        check(tx_en == 0, "R2 tx_en low", tx_en, 0);
        check(poll_clr == 1, "R3 poll pulse", poll_clr, 1);
        check(sym_sel == 1, "R4 abort selected", sym_sel, 1);
        buf_ptr_in = 16'h5678;
        tick();
        check(poll_clr == 0, "R3 poll single", poll_clr, 0);
        check(saved_ptr == 16'h1234, "R7 frozen", saved_ptr, 16'h1234);
        pull(2'd1, 8'hFF);
        check(sym_sel == 2, "R4 fill after abort", sym_sel, 2);
        idle_mode = 1'b1;
        pull(2'd3, 8'h7E);
        pull(2'd3, 8'h7E);
        idle_mode = 1'b0;
        pull(2'd2, 8'hFF);

        // R5 stop between frames, flag fill
        pulse(reinit);
        pulse(restart);
        buf_ptr_in = 16'h2222;
        idle_mode = 1'b1;
        tick();
        pulse(stop_req);
        check(sym_sel == 3, "R5 direct fill", sym_sel, 3);
        check(poll_clr == 1, "R3 poll pulse 2", poll_clr, 1);
        buf_ptr_in = 16'h3333;
        pull(2'd3, 8'h7E);
        check(saved_ptr == 16'h2222, "R7 held 2", saved_ptr, 16'h2222);

        // R9 stop while stopped
        pulse(stop_req);
        check(poll_clr == 0, "R9 no poll when stopped", poll_clr, 0);
        check(saved_ptr == 16'h2222, "R9 ptr unchanged", saved_ptr, 16'h2222);

        // R9 stop cancels arming
        pulse(reinit);
        pulse(stop_req);
        check(poll_clr == 0, "R9 no poll armed", poll_clr, 0);
        pulse(restart);
        check(tx_en == 0, "R9 disarmed restart ignored", tx_en, 0);
        tick();
        check(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule